// File: doc/BRIEF.md
# Serial Register Slave for a Four-Channel Output Converter

This block is the device side of the serial register port of a four-channel output converter. A host sends 24-bit frames on a mode-0 serial bus, most significant bit first. A frame is either a write or a read request. Writes update per-channel code, gain, offset and clear-code registers. A separate control address lets the host reach several sub-registers: per-channel slew and output-control words, plus a main word and a power-supply word that all channels share. A read request picks one register. Its 16-bit value comes back on the serial output during the next frame. During that next frame the host usually sends the no-operation word `0x1CE000`.

The serial clock, chip select and data-in pins are brought into the block's clock domain through two-flop synchronisers. Edges are then found in that domain, so the serial clock must be much slower than `clk_i`. A frame takes effect only when chip select rises after exactly 24 serial clock rising edges. The serial side has no back-pressure. The host must leave at least five `clk_i` periods per serial clock phase, and at least eight between frames, so that every edge is seen and each commit lands before the next frame starts. All register contents are driven on parallel output ports.

Top module: `spidac_regslave`

## Requirements
- R1: After reset, each channel's gain register reads 0xFFFF and each offset register reads 0x8000. Every other register, and the pending readback value, is zero.
- R2: A committed write frame (bit 23 = 0) to address 0x00–0x03 loads data bits 15:0 into the output code register of channel `addr[1:0]`. Address bits 20:16 are the address.
- R3: Write addresses 0x08–0x0B load the gain register, 0x10–0x13 load the offset register and 0x14–0x17 load the clear-code register of channel `addr[1:0]`.
- R4: A write to 0x1C–0x1F uses data bits 15:13 as a sub-register selector for channel `addr[1:0]`. Selector 0 stores bits 12:0 as the slew word (bit 12 enable, bits 11:3 rate, bits 2:0 step). Selector 2 stores bits 8:0 as the output-control word (bit 8 internal enable, bit 7 clear enable, bit 6 output enable, bit 5 internal sense resistor, bit 4 supply enable, bit 3 overrange, bits 2:0 range).
- R5: Through any of 0x1C–0x1F, selector 1 stores bits 12:0 as the shared main word. Selector 3 stores bits 6:0 as the shared supply word (bit 6 external compensation, bits 5:4 phase, bits 3:2 frequency, bits 1:0 voltage limit).
- R6: A committed read frame (bit 23 = 1) selects one register. In the following frame the slave shifts out 8 zero bits, then that 16-bit value MSB first. It drives each bit before the serial clock rising edge that samples it. A read frame changes no register.
- R7: The no-operation frame 0x1CE000 (control address, selector 7) leaves every register unchanged.
- R8: A frame with any number of serial clock rising edges other than 24 is discarded and changes no register.
- R9: Writes to 0x04–0x07, 0x0C–0x0F and 0x18–0x1B are ignored. Control writes with selector 4 to 7 are ignored.
- R10: Read addresses map as 0x00 code, 0x04 output control, 0x08 gain, 0x0C offset, 0x10 clear, 0x14 slew (each plus the channel), 0x19 main and 0x1A supply word. Narrower fields are zero-extended. Status 0x18, 0x1B and 0x1C–0x1F read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sclk_i | input | 1 | Serial clock, idles low |
| spi_cs_ni | input | 1 | Chip select, active low |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host, zero while deselected |
| dac_code_o | output | 4x16 | Output code per channel |
| gain_o | output | 4x16 | Gain trim per channel |
| offset_o | output | 4x16 | Offset trim per channel |
| clear_o | output | 4x16 | Clear code per channel |
| slew_o | output | 4x13 | Slew word per channel |
| dac_ctrl_o | output | 4x9 | Output-control word per channel |
| main_o | output | 13 | Shared main word |
| dcdc_o | output | 7 | Shared supply word |

## Verification
A wrong decode shows within a few block cycles of the chip-select rise. The wrong channel's parallel output moves, or a port that should hold its value changes. The bench compares every output group against an arithmetic model after each frame. The readback path is covered by a sweep over all 32 read addresses. A corrupted pending value only shows one frame later, as a wrong bit in the low 16 serial bits, and each read in the sweep is compared during the frame that follows it. Frame-length and no-op faults show as a register that changes when the model says it must not.

// File: rtl/spidac_pkg.sv
package spidac_pkg;
  localparam int NUM_CH     = 4;
  localparam int FRAME_BITS = 24;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int SLEW_W     = 13;
  localparam int MAIN_W     = 13;
  localparam int DCTL_W     = 9;
  localparam int DCDC_W     = 7;
  localparam int SUB_W      = 3;
  localparam int CH_W       = $clog2(NUM_CH);
  localparam int PAD_W      = FRAME_BITS - DATA_W;

  localparam logic [DATA_W-1:0] GAIN_RST = '1;
  localparam logic [DATA_W-1:0] OFFS_RST = 16'h8000;
  localparam logic [FRAME_BITS-1:0] NOOP_WORD = 24'h1CE000;

  typedef struct packed {
    logic              rd;
    logic [1:0]        spare;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  typedef enum logic [SUB_W-1:0] {
    SUB_SLEW   = 3'd0,
    SUB_MAIN   = 3'd1,
    SUB_DACCTL = 3'd2,
    SUB_DCDC   = 3'd3,
    SUB_SOFT   = 3'd4
  } ctl_sub_e;

  typedef enum logic [2:0] {
    WK_NONE, WK_DATA, WK_GAIN, WK_OFFS, WK_CLR, WK_CTRL
  } wr_kind_e;

  typedef enum logic [2:0] {
    RG_DATA = 3'd0, RG_CTRL = 3'd1, RG_GAIN = 3'd2, RG_OFFS = 3'd3,
    RG_CLR  = 3'd4, RG_SLEW = 3'd5, RG_SHARED = 3'd6, RG_NONE = 3'd7
  } rd_group_e;

  function automatic wr_kind_e wr_kind(input logic [ADDR_W-1:0] a);
    unique case (a[4:2])
      3'd0:    return WK_DATA;
      3'd2:    return WK_GAIN;
      3'd4:    return WK_OFFS;
      3'd5:    return WK_CLR;
      3'd7:    return WK_CTRL;
      default: return WK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/spidac_shifter.sv
module spidac_shifter
  import spidac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] load_i,
  output logic              miso_o,
  output logic              commit_o,
  output frame_t            frame_o
);
  localparam int CNT_W = $clog2(FRAME_BITS) + 1;
  localparam logic [CNT_W-1:0] CNT_SAT  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [2:0] sclk_q, cs_q;
  logic [1:0] mosi_q;
  logic       sclk_rise, sclk_fall, cs_fall, cs_rise, sel;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] rx_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk_i};
      cs_q   <= {cs_q[1:0], cs_ni};
      mosi_q <= {mosi_q[0], mosi_i};
    end
  end

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign sclk_fall = ~sclk_q[1] & sclk_q[2];
  assign cs_fall   = ~cs_q[1] & cs_q[2];
  assign cs_rise   = cs_q[1] & ~cs_q[2];
  assign sel       = ~cs_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else if (cs_fall) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= {{PAD_W{1'b0}}, load_i};
    end else if (sel) begin
      if (sclk_rise) begin
        rx_q <= {rx_q[FRAME_BITS-2:0], mosi_q[1]};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
      if (sclk_fall) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o <= 1'b0;
      frame_o  <= '0;
    end else begin
      commit_o <= cs_rise && (cnt_q == CNT_FULL);
      if (cs_rise) frame_o <= frame_t'(rx_q);
    end
  end

  assign miso_o = sel & tx_q[FRAME_BITS-1];
endmodule

// File: rtl/spidac_regfile.sv
module spidac_regfile
  import spidac_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           commit_i,
  input  frame_t                         frame_i,
  output logic [NUM_CH-1:0][DATA_W-1:0]  data_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  gain_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  offs_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  clr_o,
  output logic [NUM_CH-1:0][SLEW_W-1:0]  slew_o,
  output logic [NUM_CH-1:0][DCTL_W-1:0]  dctl_o,
  output logic [MAIN_W-1:0]              main_o,
  output logic [DCDC_W-1:0]              dcdc_o
);
  wr_kind_e kind;
  ctl_sub_e sub;
  logic     wr_ok;

  assign kind  = wr_kind(frame_i.addr);
  assign sub   = ctl_sub_e'(frame_i.data[DATA_W-1 -: SUB_W]);
  assign wr_ok = commit_i && !frame_i.rd;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              hit;
    logic [DATA_W-1:0] data_q, gain_q, offs_q, clr_q;
    logic [SLEW_W-1:0] slew_q;
    logic [DCTL_W-1:0] dctl_q;

    assign hit = wr_ok && (frame_i.addr[CH_W-1:0] == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q <= '0;
        gain_q <= GAIN_RST;
        offs_q <= OFFS_RST;
        clr_q  <= '0;
        slew_q <= '0;
        dctl_q <= '0;
      end else if (hit) begin
        unique case (kind)
          WK_DATA: data_q <= frame_i.data;
          WK_GAIN: gain_q <= frame_i.data;
          WK_OFFS: offs_q <= frame_i.data;
          WK_CLR:  clr_q  <= frame_i.data;
          WK_CTRL: begin
            if (sub == SUB_SLEW)   slew_q <= frame_i.data[SLEW_W-1:0];
            if (sub == SUB_DACCTL) dctl_q <= frame_i.data[DCTL_W-1:0];
          end
          default: ;
        endcase
      end
    end

    assign data_o[c] = data_q;
    assign gain_o[c] = gain_q;
    assign offs_o[c] = offs_q;
    assign clr_o[c]  = clr_q;
    assign slew_o[c] = slew_q;
    assign dctl_o[c] = dctl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_o <= '0;
      dcdc_o <= '0;
    end else if (wr_ok && kind == WK_CTRL) begin
      if (sub == SUB_MAIN) main_o <= frame_i.data[MAIN_W-1:0];
      if (sub == SUB_DCDC) dcdc_o <= frame_i.data[DCDC_W-1:0];
    end
  end
endmodule

// File: rtl/spidac_readback.sv
module spidac_readback
  import spidac_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           commit_i,
  input  frame_t                         frame_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  data_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  gain_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  offs_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  clr_i,
  input  logic [NUM_CH-1:0][SLEW_W-1:0]  slew_i,
  input  logic [NUM_CH-1:0][DCTL_W-1:0]  dctl_i,
  input  logic [MAIN_W-1:0]              main_i,
  input  logic [DCDC_W-1:0]              dcdc_i,
  output logic [DATA_W-1:0]              rdbuf_o
);
  logic [CH_W-1:0]   ch;
  rd_group_e         grp;
  logic [DATA_W-1:0] sel_val;

  assign ch  = frame_i.addr[CH_W-1:0];
  assign grp = rd_group_e'(frame_i.addr[ADDR_W-1:CH_W]);

  always_comb begin
    sel_val = '0;
    unique case (grp)
      RG_DATA: sel_val = data_i[ch];
      RG_CTRL: sel_val = DATA_W'(dctl_i[ch]);
      RG_GAIN: sel_val = gain_i[ch];
      RG_OFFS: sel_val = offs_i[ch];
      RG_CLR:  sel_val = clr_i[ch];
      RG_SLEW: sel_val = DATA_W'(slew_i[ch]);
      RG_SHARED: begin
        if (ch == CH_W'(1)) sel_val = DATA_W'(main_i);
        if (ch == CH_W'(2)) sel_val = DATA_W'(dcdc_i);
      end
      default: sel_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rdbuf_o <= '0;
    else if (commit_i && frame_i.rd) rdbuf_o <= sel_val;
  end
endmodule

// File: rtl/spidac_regslave.sv
module spidac_regslave
  import spidac_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          spi_sclk_i,
  input  logic                          spi_cs_ni,
  input  logic                          spi_mosi_i,
  output logic                          spi_miso_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] dac_code_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] gain_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] offset_o,
  output logic [NUM_CH-1:0][DATA_W-1:0] clear_o,
  output logic [NUM_CH-1:0][SLEW_W-1:0] slew_o,
  output logic [NUM_CH-1:0][DCTL_W-1:0] dac_ctrl_o,
  output logic [MAIN_W-1:0]             main_o,
  output logic [DCDC_W-1:0]             dcdc_o
);
  logic              commit_w;
  frame_t            frame_w;
  logic [DATA_W-1:0] rdbuf_w;

  spidac_shifter u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (spi_sclk_i),
    .cs_ni    (spi_cs_ni),
    .mosi_i   (spi_mosi_i),
    .load_i   (rdbuf_w),
    .miso_o   (spi_miso_o),
    .commit_o (commit_w),
    .frame_o  (frame_w)
  );

  spidac_regfile u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit_w),
    .frame_i  (frame_w),
    .data_o   (dac_code_o),
    .gain_o   (gain_o),
    .offs_o   (offset_o),
    .clr_o    (clear_o),
    .slew_o   (slew_o),
    .dctl_o   (dac_ctrl_o),
    .main_o   (main_o),
    .dcdc_o   (dcdc_o)
  );

  spidac_readback u_rdbk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit_w),
    .frame_i  (frame_w),
    .data_i   (dac_code_o),
    .gain_i   (gain_o),
    .offs_i   (offset_o),
    .clr_i    (clear_o),
    .slew_i   (slew_o),
    .dctl_i   (dac_ctrl_o),
    .main_i   (main_o),
    .dcdc_i   (dcdc_o),
    .rdbuf_o  (rdbuf_w)
  );
endmodule

// File: rtl/spidac_regslave_chk.sv
module spidac_regslave_chk
  import spidac_pkg::*;
(
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          commit_i,
  input logic [FRAME_BITS-1:0]         frame_i,
  input logic [DATA_W-1:0]             rdbuf_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] dac_code_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] gain_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] offset_i,
  input logic [NUM_CH-1:0][DATA_W-1:0] clear_i,
  input logic [NUM_CH-1:0][SLEW_W-1:0] slew_i,
  input logic [NUM_CH-1:0][DCTL_W-1:0] dac_ctrl_i,
  input logic [MAIN_W-1:0]             main_i,
  input logic [DCDC_W-1:0]             dcdc_i
);
  logic [NUM_CH*(4*DATA_W+SLEW_W+DCTL_W)+MAIN_W+DCDC_W-1:0] all_regs;
  logic is_wr, is_rd, wr_unmapped, rd_unmapped;
  logic [4:0] a;

  assign all_regs = {dac_code_i, gain_i, offset_i, clear_i, slew_i, dac_ctrl_i, main_i, dcdc_i};
  assign a        = frame_i[20:16];
  assign is_wr    = commit_i && !frame_i[23];
  assign is_rd    = commit_i && frame_i[23];
  assign wr_unmapped = (a[4:2] == 3'd1) || (a[4:2] == 3'd3) || (a[4:2] == 3'd6);
  assign rd_unmapped = (a == 5'h18) || (a > 5'h1A);

  // R2: a committed code write lands in the addressed channel
  a_r2_code_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && a[4:2] == 3'd0) |=> (dac_code_i[$past(frame_i[17:16])] == $past(frame_i[15:0])));

  // R7: the no-op word leaves all registers alone
  a_r7_noop_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && frame_i == NOOP_WORD) |=> $stable(all_regs));

  // R8: registers only move right after a committed frame
  a_r8_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit_i) |-> $stable(all_regs));

  // R9: unmapped write addresses are ignored
  a_r9_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_wr && wr_unmapped) |=> $stable(all_regs));

  // R10: unmapped or status reads queue a zero
  a_r10_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rd && rd_unmapped) |=> (rdbuf_i == '0));
endmodule

bind spidac_regslave spidac_regslave_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .commit_i   (commit_w),
  .frame_i    (frame_w),
  .rdbuf_i    (rdbuf_w),
  .dac_code_i (dac_code_o),
  .gain_i     (gain_o),
  .offset_i   (offset_o),
  .clear_i    (clear_o),
  .slew_i     (slew_o),
  .dac_ctrl_i (dac_ctrl_o),
  .main_i     (main_o),
  .dcdc_i     (dcdc_o)
);

// File: tb/spidac_regslave_tb_top.sv
module spidac_regslave_tb_top;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [3:0][15:0] dac_code, gain, offset, clear;
  logic [3:0][12:0] slew;
  logic [3:0][8:0]  dctl;
  logic [12:0] main_w;
  logic [6:0]  dcdc;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [15:0] m_data[4], m_gain[4], m_offs[4], m_clr[4];
  logic [12:0] m_slew[4];
  logic [8:0]  m_dctl[4];
  logic [12:0] m_main;
  logic [6:0]  m_dcdc;

  always #10 clk = ~clk;

  spidac_regslave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .spi_sclk_i(sclk), .spi_cs_ni(cs_n),
    .spi_mosi_i(mosi), .spi_miso_o(miso), .dac_code_o(dac_code),
    .gain_o(gain), .offset_o(offset), .clear_o(clear), .slew_o(slew),
    .dac_ctrl_o(dctl), .main_o(main_w), .dcdc_o(dcdc)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      m_data[c] = '0; m_gain[c] = 16'hFFFF; m_offs[c] = 16'h8000;
      m_clr[c] = '0; m_slew[c] = '0; m_dctl[c] = '0;
    end
    m_main = '0; m_dcdc = '0;
  endtask

  // Write decode per R2..R5, R9
  task automatic model_write(input logic [23:0] w);
    logic [4:0] a = w[20:16];
    logic [15:0] d = w[15:0];
    int c = int'(a[1:0]);
    if (w[23]) return;
    case (a[4:2])
      3'd0: m_data[c] = d;
      3'd2: m_gain[c] = d;
      3'd4: m_offs[c] = d;
      3'd5: m_clr[c] = d;
      3'd7: case (d[15:13])
              3'd0: m_slew[c] = d[12:0];
              3'd1: m_main = d[12:0];
              3'd2: m_dctl[c] = d[8:0];
              3'd3: m_dcdc = d[6:0];
              default: ;
            endcase
      default: ;
    endcase
  endtask

  // Read map per R10
  function automatic logic [15:0] model_read(input logic [4:0] a);
    int c = int'(a[1:0]);
    case (a[4:2])
      3'd0: return m_data[c];
      3'd1: return {7'b0, m_dctl[c]};
      3'd2: return m_gain[c];
      3'd3: return m_offs[c];
      3'd4: return m_clr[c];
      3'd5: return {3'b0, m_slew[c]};
      3'd6: if (a[1:0] == 2'd1) return {3'b0, m_main};
            else if (a[1:0] == 2'd2) return {9'b0, m_dcdc};
            else return '0;
      default: return '0;
    endcase
  endfunction

  task automatic check_regs(input string tag);
    logic [63:0] e_data, e_gain, e_offs, e_clr, e_slew, e_dctl;
    for (int c = 0; c < 4; c++) begin
      e_data[c*16 +: 16] = m_data[c];
      e_gain[c*16 +: 16] = m_gain[c];
      e_offs[c*16 +: 16] = m_offs[c];
      e_clr[c*16 +: 16]  = m_clr[c];
    end
    e_slew = {12'b0, m_slew[3], m_slew[2], m_slew[1], m_slew[0]};
    e_dctl = {28'b0, m_dctl[3], m_dctl[2], m_dctl[1], m_dctl[0]};
    chk(dac_code == e_data, {tag, " code"}, dac_code, e_data);
    chk(gain == e_gain, {tag, " gain"}, gain, e_gain);
    chk(offset == e_offs, {tag, " offset"}, offset, e_offs);
    chk(clear == e_clr, {tag, " clear"}, clear, e_clr);
    chk({12'b0, slew} == e_slew, {tag, " slew"}, {12'b0, slew}, e_slew);
    chk({28'b0, dctl} == e_dctl, {tag, " dacctl"}, {28'b0, dctl}, e_dctl);
    chk({m_dcdc, m_main} == {dcdc, main_w}, {tag, " shared"}, {dcdc, main_w}, {m_dcdc, m_main});
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] rx);
    rx = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? w[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      rx = {rx[22:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*HALF + 4) @(negedge clk);
    if (nbits == 24) model_write(w);
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'((a + 1) * 16'h2F1B) ^ 16'(a << 7);
  endfunction

  function automatic string wtag(input logic [4:0] a, input logic [2:0] sub);
    case (a[4:2])
      3'd0: return "R2";
      3'd2, 3'd4, 3'd5: return "R3";
      3'd7: return (sub == 3'd0 || sub == 3'd2) ? "R4" :
                   (sub == 3'd1 || sub == 3'd3) ? "R5" : "R9";
      default: return "R9";
    endcase
  endfunction

  task automatic read_sweep(input string note);
    logic [23:0] rx, w;
    for (int a = 0; a <= 32; a++) begin
      w = (a < 32) ? {1'b1, 2'b00, 5'(a), 16'h0} : 24'h1CE000;
      xfer(w, 24, rx);
      if (a > 0) begin
        logic [23:0] e = {8'h00, model_read(5'(a - 1))};
        logic [4:0] pa = 5'(a - 1);
        string t = (pa == 5'h18 || pa > 5'h1A) ? "R10" : "R6";
        chk(rx == e, {t, " readback ", note}, {40'b0, rx}, {40'b0, e});
      end
    end
    check_regs("R6 read frames change nothing");
  endtask

  initial begin
    logic [23:0] rx;
    logic [23:0] w;
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_regs("R1 reset");
    chk(miso == 1'b0, "R6 idle miso", {63'b0, miso}, 64'd0);
    read_sweep("after R1 reset");

    // Write sweep across the whole write map
    for (int a = 0; a < 32; a++) begin
      w = {1'b0, 2'b00, 5'(a), pat(a)};
      xfer(w, 24, rx);
      check_regs(wtag(5'(a), w[15:13]));
    end

    // Control selector sweep, each channel, every selector
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 8; s++) begin
        w = {1'b0, 2'b00, 3'b111, 2'(c), 3'(s), 13'(pat(c * 8 + s + 40))};
        xfer(w, 24, rx);
        check_regs(wtag(5'h1C, 3'(s)));
      end

    // R7: no-op frame
    xfer(24'h1CE000, 24, rx);
    check_regs("R7 noop");

    // R8: wrong frame lengths
    xfer({8'h02, 16'hA5A5}, 23, rx);
    check_regs("R8 23 clocks");
    xfer({8'h02, 16'h5A5A}, 25, rx);
    check_regs("R8 25 clocks");
    xfer({8'h01, 16'h1234}, 8, rx);
    check_regs("R8 8 clocks");
    xfer({8'h02, 16'hC3C3}, 24, rx);
    check_regs("R2 write after short frames");

    // R6: read followed by a write frame still returns the value
    xfer({8'h8A, 16'h0000}, 24, rx);
    xfer({8'h03, 16'h0F0F}, 24, rx);
    chk(rx == {8'h00, m_gain[2]}, "R6 read then write", {40'b0, rx}, {40'b0, 8'h00, m_gain[2]});
    check_regs("R2 write during readback");

    read_sweep("after writes");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule